// File: doc/BRIEF.md
# Banked Peripheral Card Address Decoder

This block turns a 16-bit processor address into the chip selects of a peripheral card that carries three targets: an 8 KB program ROM shown through a 4 KB window, a 2 KB buffer RAM, and a disk controller with four byte registers. For each access it produces one select, plus the local address or register index that goes with it. A bank flag chooses which half of the ROM appears in the window. Writes never reach the ROM.

Every output is registered, so it reflects the inputs sampled at the previous rising clock edge. When no target is selected, every address and index output is forced to zero. The `bus_drive` output tells the card's data buffer when to drive the read bus. When nothing is selected, or the access is a write, the bus is left undriven.

The controller decode tests only the upper address byte and bit 0. Because of this, every odd address from 0x5F01 to 0x5FFF reaches the controller, and address bits [2:1] select one of the four registers. Software uses 0x5F01, 0x5F03, 0x5F05 and 0x5F07. Higher odd addresses in that page alias onto the same four registers.

Top module: `pcard_decoder`

## Requirements
- R1: While `rst` is high at a rising edge, all selects, `bus_drive` and all address and index outputs are 0 after that edge.
- R2: When `card_en` is low, no select and no `bus_drive` is asserted after the edge, whatever the address.
- R3: A read (`acc_valid`=1, `acc_write`=0) to 0x4000–0x4FFF with `card_en`=1 asserts `rom_sel`. `rom_addr` equals {`bank_sel`, addr[11:0]}, so `bank_sel`=1 reaches ROM bytes 0x1000–0x1FFF.
- R4: A write (`acc_write`=1) to 0x4000–0x4FFF never asserts `rom_sel`.
- R5: A read or write to 0x5000–0x57FF with `card_en`=1 asserts `ram_sel`, with `ram_addr` = addr[10:0].
- R6: A read or write to an address whose upper byte is 0x5F and whose bit 0 is 1, with `card_en`=1, asserts `ctl_sel`, with `ctl_reg` = addr[2:1]. Even addresses in that page select nothing.
- R7: At most one of `rom_sel`, `ram_sel` and `ctl_sel` is high in any cycle. Addresses outside the three windows (for example 0x5800–0x5EFF, 0x3FFF, 0x6000) select nothing.
- R8: `bus_drive` is high exactly when a select is high and the access was a read.
- R9: With `acc_valid` low, nothing is selected. The outputs of any cycle follow the inputs sampled one rising edge earlier. When no select is active, `rom_addr`, `ram_addr` and `ctl_reg` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | 16 | Processor byte address |
| acc_valid | input | 1 | An access is present this cycle |
| acc_write | input | 1 | 1 = write, 0 = read |
| card_en | input | 1 | Card is enabled |
| bank_sel | input | 1 | Selects the upper ROM half |
| rom_sel | output | 1 | ROM chip select |
| rom_addr | output | 13 | ROM byte address |
| ram_sel | output | 1 | Buffer RAM chip select |
| ram_addr | output | 11 | RAM byte address |
| ctl_sel | output | 1 | Disk controller select |
| ctl_reg | output | 2 | Controller register index |
| bus_drive | output | 1 | Drive the read data bus |

## Verification
The bank flag and a ROM read fall in the same cycle. The bench toggles `bank_sel` on consecutive ROM reads at the same offset and checks bit 12 of `rom_addr` against the flag that was sampled with each read. The write gate and the ROM window hit also coincide. Writes aimed at 0x4000–0x4FFF must return no select and no drive in the very cycle that a read to the same address would select the ROM. Random traffic mixes both situations with the RAM and controller windows and with the card disabled.

// File: rtl/pcard_pkg.sv
package pcard_pkg;

    localparam int ADDR_W = 16;

    typedef struct packed {
        logic rom;
        logic ram;
        logic ctl;
    } sel_t;

    function automatic logic window_hit(
        input logic [ADDR_W-1:0] a,
        input logic [ADDR_W-1:0] base,
        input logic [ADDR_W-1:0] mask
    );
        return (a & mask) == base;
    endfunction

    function automatic logic any_sel(input sel_t s);
        return s.rom | s.ram | s.ctl;
    endfunction

endpackage

// File: rtl/pcard_window.sv
module pcard_window
    import pcard_pkg::*;
#(
    parameter logic [ADDR_W-1:0] BASE    = 16'h5000,
    parameter logic [ADDR_W-1:0] MASK    = 16'hF800,
    parameter int                OFS_W   = 11,
    parameter int                OFS_LSB = 0
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              hit,
    output logic [OFS_W-1:0]  offset
);
    always_comb begin
        hit    = window_hit(addr, BASE, MASK);
        offset = addr[OFS_LSB +: OFS_W];
    end
endmodule

// File: rtl/pcard_rom_map.sv
module pcard_rom_map
    import pcard_pkg::*;
#(
    parameter int PAGE_W = 12,
    localparam int ROM_AW = PAGE_W + 1
) (
    input  logic              hit,
    input  logic              is_write,
    input  logic              bank,
    input  logic [PAGE_W-1:0] page_ofs,
    output logic              sel,
    output logic [ROM_AW-1:0] rom_a
);
    always_comb begin
        sel   = hit & ~is_write;
        rom_a = {bank, page_ofs};
    end
endmodule

// File: rtl/pcard_decoder.sv
module pcard_decoder
    import pcard_pkg::*;
#(
    parameter logic [ADDR_W-1:0] ROM_BASE = 16'h4000,
    parameter logic [ADDR_W-1:0] ROM_MASK = 16'hF000,
    parameter logic [ADDR_W-1:0] RAM_BASE = 16'h5000,
    parameter logic [ADDR_W-1:0] RAM_MASK = 16'hF800,
    parameter logic [ADDR_W-1:0] CTL_BASE = 16'h5F01,
    parameter logic [ADDR_W-1:0] CTL_MASK = 16'hFF01,
    parameter int PAGE_W = 12,
    parameter int RAM_AW = 11,
    parameter int REG_W  = 2,
    localparam int ROM_AW = PAGE_W + 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr,
    input  logic              acc_valid,
    input  logic              acc_write,
    input  logic              card_en,
    input  logic              bank_sel,
    output logic              rom_sel,
    output logic [ROM_AW-1:0] rom_addr,
    output logic              ram_sel,
    output logic [RAM_AW-1:0] ram_addr,
    output logic              ctl_sel,
    output logic [REG_W-1:0]  ctl_reg,
    output logic              bus_drive
);
    logic              rom_hit, ram_hit, ctl_hit, rom_ok;
    logic [PAGE_W-1:0] rom_ofs;
    logic [ROM_AW-1:0] rom_a;
    logic [RAM_AW-1:0] ram_ofs;
    logic [REG_W-1:0]  ctl_ofs;
    logic              gate;
    sel_t              sel_d, sel_q;

    pcard_window #(.BASE(ROM_BASE), .MASK(ROM_MASK), .OFS_W(PAGE_W), .OFS_LSB(0))
        u_rom_win (.addr(addr), .hit(rom_hit), .offset(rom_ofs));
    pcard_window #(.BASE(RAM_BASE), .MASK(RAM_MASK), .OFS_W(RAM_AW), .OFS_LSB(0))
        u_ram_win (.addr(addr), .hit(ram_hit), .offset(ram_ofs));
    pcard_window #(.BASE(CTL_BASE), .MASK(CTL_MASK), .OFS_W(REG_W), .OFS_LSB(1))
        u_ctl_win (.addr(addr), .hit(ctl_hit), .offset(ctl_ofs));

    pcard_rom_map #(.PAGE_W(PAGE_W)) u_rom_map (
        .hit(rom_hit), .is_write(acc_write), .bank(bank_sel),
        .page_ofs(rom_ofs), .sel(rom_ok), .rom_a(rom_a)
    );

    always_comb begin
        gate      = acc_valid & card_en;
        sel_d.rom = gate & rom_ok;
        sel_d.ram = gate & ram_hit;
        sel_d.ctl = gate & ctl_hit;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sel_q     <= '0;
            rom_addr  <= '0;
            ram_addr  <= '0;
            ctl_reg   <= '0;
            bus_drive <= 1'b0;
        end else begin
            sel_q     <= sel_d;
            rom_addr  <= sel_d.rom ? rom_a   : '0;
            ram_addr  <= sel_d.ram ? ram_ofs : '0;
            ctl_reg   <= sel_d.ctl ? ctl_ofs : '0;
            bus_drive <= any_sel(sel_d) & ~acc_write;
        end
    end

    assign rom_sel = sel_q.rom;
    assign ram_sel = sel_q.ram;
    assign ctl_sel = sel_q.ctl;

    // R1: reset clears the selects
    assert_reset_clear_R1: assert property (@(posedge clk)
        rst |=> !(rom_sel || ram_sel || ctl_sel || bus_drive));
    // R2: a disabled card stays silent
    assert_card_off_R2: assert property (@(posedge clk) disable iff (rst)
        !card_en |=> !(rom_sel || ram_sel || ctl_sel || bus_drive));
    // R3: the bank flag lands in the top ROM address bit
    assert_rom_bank_R3: assert property (@(posedge clk) disable iff (rst)
        (acc_valid && card_en && !acc_write && addr[15:12] == 4'h4)
            |=> (rom_sel && rom_addr[PAGE_W] == $past(bank_sel)));
    // R4: the ROM cannot be written
    assert_rom_readonly_R4: assert property (@(posedge clk) disable iff (rst)
        (acc_valid && acc_write) |=> !rom_sel);
    // R7: the selects are exclusive
    assert_one_target_R7: assert property (@(posedge clk) disable iff (rst)
        $onehot0({rom_sel, ram_sel, ctl_sel}));
    // R8: the bus is driven only on a selected read
    assert_drive_R8: assert property (@(posedge clk) disable iff (rst)
        bus_drive |-> (rom_sel || ram_sel || ctl_sel) && !$past(acc_write));
    // R9: no access, no select
    assert_idle_R9: assert property (@(posedge clk) disable iff (rst)
        !acc_valid |=> !(rom_sel || ram_sel || ctl_sel));
endmodule

// File: tb/pcard_decoder_test.sv
module pcard_decoder_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst;
    logic [15:0] addr;
    logic        acc_valid, acc_write, card_en, bank_sel;
    logic        rom_sel, ram_sel, ctl_sel, bus_drive;
    logic [12:0] rom_addr;
    logic [10:0] ram_addr;
    logic [1:0]  ctl_reg;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    // expected outputs for the inputs applied in the previous step
    bit      e_rom, e_ram, e_ctl, e_drv;
    int      e_rom_a, e_ram_a, e_reg;
    string   e_tag;

    always #(CLK_PERIOD/2) clk = ~clk;

    pcard_decoder uut (
        .clk(clk), .rst(rst), .addr(addr), .acc_valid(acc_valid),
        .acc_write(acc_write), .card_en(card_en), .bank_sel(bank_sel),
        .rom_sel(rom_sel), .rom_addr(rom_addr), .ram_sel(ram_sel),
        .ram_addr(ram_addr), .ctl_sel(ctl_sel), .ctl_reg(ctl_reg),
        .bus_drive(bus_drive)
    );

    task automatic cmp(string tag, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    task automatic check_now();
        cmp(e_tag, "rom_sel (R3)", int'(rom_sel), int'(e_rom));
        cmp(e_tag, "rom_addr (R3)", int'(rom_addr), e_rom_a);
        cmp(e_tag, "ram_sel (R5)", int'(ram_sel), int'(e_ram));
        cmp(e_tag, "ram_addr (R5)", int'(ram_addr), e_ram_a);
        cmp(e_tag, "ctl_sel (R6)", int'(ctl_sel), int'(e_ctl));
        cmp(e_tag, "ctl_reg (R6)", int'(ctl_reg), e_reg);
        cmp(e_tag, "bus_drive (R8)", int'(bus_drive), int'(e_drv));
        cmp(e_tag, "exclusive selects (R7)",
            int'(rom_sel) + int'(ram_sel) + int'(ctl_sel) > 1 ? 1 : 0, 0);
    endtask

    // behavioural model of one access
    task automatic model(bit r, int a, bit v, bit w, bit en, bit bk, string tag);
        bit live;
        live    = !r && v && en;
        e_rom   = live && !w && a >= 'h4000 && a <= 'h4FFF;
        e_ram   = live && a >= 'h5000 && a <= 'h57FF;
        e_ctl   = live && (a / 256) == 'h5F && (a % 2) == 1;
        e_drv   = (e_rom || e_ram || e_ctl) && !w;
        e_rom_a = e_rom ? (bk ? 4096 : 0) + (a % 4096) : 0;
        e_ram_a = e_ram ? a % 2048 : 0;
        e_reg   = e_ctl ? (a / 2) % 4 : 0;
        e_tag   = tag;
    endtask

    // one clock: check the result of the previous step, then apply new inputs
    task automatic step(bit r, int a, bit v, bit w, bit en, bit bk, string tag);
        check_now();
        rst = r; addr = a[15:0]; acc_valid = v; acc_write = w;
        card_en = en; bank_sel = bk;
        model(r, a, v, w, en, bk, tag);
        @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        rst = 1'b1; addr = 16'h4000; acc_valid = 1'b1; acc_write = 1'b0;
        card_en = 1'b1; bank_sel = 1'b1;
        model(1, 'h4000, 1, 0, 1, 1, "R1");
        @(posedge clk);
        @(negedge clk);
        // R1: reset state, even with a ROM read presented
        step(1, 'h4123, 1, 0, 1, 1, "R1");
        // R3: ROM reads, bank toggled on consecutive reads
        step(0, 'h4000, 1, 0, 1, 0, "R3");
        step(0, 'h4ABC, 1, 0, 1, 1, "R3");
        step(0, 'h4ABC, 1, 0, 1, 0, "R3");
        step(0, 'h4FFF, 1, 0, 1, 1, "R3");
        // R4: writes into the ROM window
        step(0, 'h4ABC, 1, 1, 1, 1, "R4");
        step(0, 'h4000, 1, 1, 1, 0, "R4");
        // R5: RAM read/write and edges
        step(0, 'h5000, 1, 0, 1, 0, "R5");
        step(0, 'h57FF, 1, 1, 1, 1, "R5");
        step(0, 'h5432, 1, 0, 1, 0, "R5");
        // R6: controller registers, even addresses, alias
        step(0, 'h5F01, 1, 0, 1, 0, "R6");
        step(0, 'h5F03, 1, 1, 1, 0, "R6");
        step(0, 'h5F05, 1, 0, 1, 0, "R6");
        step(0, 'h5F07, 1, 1, 1, 0, "R6");
        step(0, 'h5F02, 1, 0, 1, 0, "R6");
        step(0, 'h5FFF, 1, 0, 1, 0, "R6");
        // R7: gaps between windows
        step(0, 'h5800, 1, 0, 1, 0, "R7");
        step(0, 'h5EFF, 1, 0, 1, 0, "R7");
        step(0, 'h3FFF, 1, 0, 1, 0, "R7");
        step(0, 'h6000, 1, 1, 1, 0, "R7");
        // R2: card disabled
        step(0, 'h4100, 1, 0, 0, 0, "R2");
        step(0, 'h5100, 1, 1, 0, 0, "R2");
        step(0, 'h5F01, 1, 0, 0, 0, "R2");
        // R9: no access present
        step(0, 'h4100, 0, 0, 1, 1, "R9");
        step(0, 'h5F03, 0, 0, 1, 0, "R9");
        // R8: selected writes leave the bus undriven
        step(0, 'h5F05, 1, 1, 1, 0, "R8");
        step(0, 'h5005, 1, 0, 1, 0, "R8");
        // mixed random traffic
        for (int i = 0; i < 3000; i++) begin
            int a;
            int pick;
            pick = $urandom_range(0, 5);
            case (pick)
                0: a = 'h4000 + $urandom_range(0, 'hFFF);
                1: a = 'h5000 + $urandom_range(0, 'h7FF);
                2: a = 'h5F00 + $urandom_range(0, 'hFF);
                3: a = 'h5800 + $urandom_range(0, 'h7FF);
                default: a = $urandom_range(0, 'hFFFF);
            endcase
            step(0, a, $urandom_range(0, 7) != 0, $urandom_range(0, 2) == 0,
                 $urandom_range(0, 7) != 0, $urandom_range(0, 1) == 1, "R9");
        end
        step(1, 'h4000, 1, 0, 1, 0, "R1");
        check_now();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            errors++;
            $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule